// File: doc/BRIEF.md
# Hamming 7-4 Single-Error Corrector

This block holds two independent registered paths for a seven-bit code that carries four data bits and three check bits. The encode path takes a four-bit nibble and produces the seven-bit protected word. The decode path takes a received seven-bit word and computes a three-bit syndrome from it. If exactly one bit of the word was flipped, whether a data bit or a check bit, the decode path inverts that bit and returns the repaired nibble. It also reports the syndrome and an error flag.

Each path has a single-bit valid input. Its result appears one cycle later together with a valid output, and the result registers hold their value until the next valid input. The codeword layout places each check bit at a power-of-two position. This makes a nonzero syndrome equal to the one-based position of the bit to invert. The check-bit count is a parameter, and the data width and codeword width are derived from it.

Top module: `ham74_codec`

## Requirements
- R1: For data d3..d0 the encoded word, bit 6 down to bit 0, is d3 d2 d1 c2 d0 c1 c0, with c0 = d0^d1^d3, c1 = d0^d2^d3 and c2 = d1^d2^d3.
- R2: encValidOut is high exactly one cycle after a cycle with encValidIn high, and encCodeOut carries the word for the nibble captured in that cycle.
- R3: The syndrome bits are s0 = w0^w2^w4^w6, s1 = w1^w2^w5^w6 and s2 = w3^w4^w5^w6 over the received word w, presented on decSyndrome as {s2,s1,s0}.
- R4: A received word whose syndrome is 000 yields its data bits unchanged and a low decError.
- R5: A word with one flipped bit at position p (1 to 7, bit p-1) yields syndrome p, and decDataOut is the original nibble, including when p is a check-bit position (1, 2 or 4).
- R6: decError is high exactly when decSyndrome is nonzero.
- R7: decValidOut is high exactly one cycle after a cycle with decValidIn high, and the three decode outputs belong to the word captured in that cycle.
- R8: While a path's valid input is low, changes on its data input have no effect on that path's result outputs.
- R9: After reset, all valid outputs, the code word, the data, the syndrome and the error flag are zero.
- R10: Nibble 1011 encodes to 1010101, and the received word 1000101 gives syndrome 101 and data 1011.
- R11: With two flipped bits, the syndrome is the XOR of the two positions, decError is high, and the bit at that position is inverted. For word 1010101 with bits 0 and 1 flipped, the syndrome is 011 and the data is 1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| encValidIn | input | 1 | Nibble on encDataIn is to be encoded |
| encDataIn | input | 4 | Data nibble to encode |
| encValidOut | output | 1 | encCodeOut was updated in the previous cycle |
| encCodeOut | output | 7 | Registered protected word |
| decValidIn | input | 1 | Word on decCodeIn is to be decoded |
| decCodeIn | input | 7 | Received word |
| decValidOut | output | 1 | Decode outputs were updated in the previous cycle |
| decDataOut | output | 4 | Repaired data nibble |
| decSyndrome | output | 3 | Syndrome; nonzero value is the flipped position |
| decError | output | 1 | Syndrome is nonzero |

## Verification
Words with a single flipped check bit are the hardest case to reach from the ports. An encoder never emits them, and a decoder that corrected only data bits would still return the right nibble. The bench therefore takes every table codeword and decodes it eight times: once unchanged, and once with each of the seven positions flipped. For every case it checks the syndrome as well as the data. A double flip is also injected to pin down the defined miscorrection.

// File: rtl/ham74_pkg.sv
package ham74_pkg;
  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } ham74_strobe_t;
endpackage

// File: rtl/ham74_ctrl.sv
module ham74_ctrl
  import ham74_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          encValidIn,
  input  logic          decValidIn,
  output ham74_strobe_t strobe,
  output logic          encValidOut,
  output logic          decValidOut
);
  always_comb begin
    strobe.encLoad = encValidIn;
    strobe.decLoad = decValidIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      encValidOut <= 1'b0;
      decValidOut <= 1'b0;
    end else begin
      encValidOut <= encValidIn;
      decValidOut <= decValidIn;
    end
  end
endmodule

// File: rtl/ham74_datapath.sv
module ham74_datapath
  import ham74_pkg::*;
#(
  parameter  int PAR_W  = 3,
  localparam int CODE_W = (1 << PAR_W) - 1,
  localparam int DATA_W = CODE_W - PAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ham74_strobe_t     strobe,
  input  logic [DATA_W-1:0] encDataIn,
  input  logic [CODE_W-1:0] decCodeIn,
  output logic [CODE_W-1:0] encCodeOut,
  output logic [DATA_W-1:0] decDataOut,
  output logic [PAR_W-1:0]  decSyndrome,
  output logic              decError
);
  // Positions (1-based) covered by check bit k: those whose index has bit k set.
  function automatic logic [CODE_W-1:0] coverMask(input int k);
    logic [CODE_W-1:0] m;
    for (int p = 1; p <= CODE_W; p++) m[p-1] = ((p >> k) & 1) == 1;
    return m;
  endfunction

  function automatic logic [CODE_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p-1] = d[di];
        di++;
      end
    end
    for (int k = 0; k < PAR_W; k++) c[(1 << k) - 1] = ^(c & coverMask(k));
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] extractData(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int di;
    d  = '0;
    di = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[di] = c[p-1];
        di++;
      end
    end
    return d;
  endfunction

  logic [PAR_W-1:0]  synNow;
  logic [CODE_W-1:0] flipMask;
  logic [CODE_W-1:0] fixedWord;
  logic [CODE_W-1:0] encNext;

  assign encNext = encodeWord(encDataIn);

  genvar gk;
  generate
    for (gk = 0; gk < PAR_W; gk++) begin : g_syn
      assign synNow[gk] = ^(decCodeIn & coverMask(gk));
    end
  endgenerate

  always_comb begin
    flipMask = '0;
    for (int p = 1; p <= CODE_W; p++)
      if (int'(synNow) == p) flipMask[p-1] = 1'b1;
    fixedWord = decCodeIn ^ flipMask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      encCodeOut  <= '0;
      decDataOut  <= '0;
      decSyndrome <= '0;
      decError    <= 1'b0;
    end else begin
      if (strobe.encLoad) encCodeOut <= encNext;
      if (strobe.decLoad) begin
        decDataOut  <= extractData(fixedWord);
        decSyndrome <= synNow;
        decError    <= |synNow;
      end
    end
  end
endmodule

// File: rtl/ham74_codec.sv
module ham74_codec
  import ham74_pkg::*;
#(
  parameter  int PAR_W  = 3,
  localparam int CODE_W = (1 << PAR_W) - 1,
  localparam int DATA_W = CODE_W - PAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              encValidIn,
  input  logic [DATA_W-1:0] encDataIn,
  output logic              encValidOut,
  output logic [CODE_W-1:0] encCodeOut,
  input  logic              decValidIn,
  input  logic [CODE_W-1:0] decCodeIn,
  output logic              decValidOut,
  output logic [DATA_W-1:0] decDataOut,
  output logic [PAR_W-1:0]  decSyndrome,
  output logic              decError
);
  ham74_strobe_t strobe;

  ham74_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .encValidIn  (encValidIn),
    .decValidIn  (decValidIn),
    .strobe      (strobe),
    .encValidOut (encValidOut),
    .decValidOut (decValidOut)
  );

  ham74_datapath #(.PAR_W(PAR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .encDataIn   (encDataIn),
    .decCodeIn   (decCodeIn),
    .encCodeOut  (encCodeOut),
    .decDataOut  (decDataOut),
    .decSyndrome (decSyndrome),
    .decError    (decError)
  );
endmodule

// File: rtl/ham74_codec_chk.sv
module ham74_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       encValidIn,
  input logic       encValidOut,
  input logic [6:0] encCodeOut,
  input logic       decValidIn,
  input logic [6:0] decCodeIn,
  input logic       decValidOut,
  input logic [2:0] decSyndrome,
  input logic       decError
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R1
  enc_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    encValidOut |-> (^(encCodeOut & 7'b1010101) == 1'b0) &&
                    (^(encCodeOut & 7'b1100110) == 1'b0) &&
                    (^(encCodeOut & 7'b1111000) == 1'b0));

  // R2
  enc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> encValidOut == $past(encValidIn));

  // R7
  dec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> decValidOut == $past(decValidIn));

  // R8
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !encValidIn) |=> $stable(encCodeOut));

  // R8
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !decValidIn) |=> $stable(decSyndrome) && $stable(decError));

  // R6
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decError == (decSyndrome != 3'd0));

  // R3
  syn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decValidIn && ((decCodeIn == 7'h00) || (decCodeIn == 7'h7F))) |=> decSyndrome == 3'd0);
endmodule

bind ham74_codec ham74_codec_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .encValidIn  (encValidIn),
  .encValidOut (encValidOut),
  .encCodeOut  (encCodeOut),
  .decValidIn  (decValidIn),
  .decCodeIn   (decCodeIn),
  .decValidOut (decValidOut),
  .decSyndrome (decSyndrome),
  .decError    (decError)
);

// File: tb/ham74_codec_test.sv
module ham74_codec_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {data nibble, expected codeword}
  localparam logic [10:0] VEC [NVEC] = '{
    {4'b0000, 7'h00}, {4'b0001, 7'h07}, {4'b0010, 7'h19}, {4'b0100, 7'h2A},
    {4'b1000, 7'h4B}, {4'b1011, 7'h55}, {4'b1111, 7'h7F}, {4'b0110, 7'h33}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic encValidIn = 1'b0;
  logic [3:0] encDataIn = '0;
  logic encValidOut;
  logic [6:0] encCodeOut;
  logic decValidIn = 1'b0;
  logic [6:0] decCodeIn = '0;
  logic decValidOut;
  logic [3:0] decDataOut;
  logic [2:0] decSyndrome;
  logic decError;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ham74_codec uut (
    .clk(clk), .rst_n(rst_n),
    .encValidIn(encValidIn), .encDataIn(encDataIn),
    .encValidOut(encValidOut), .encCodeOut(encCodeOut),
    .decValidIn(decValidIn), .decCodeIn(decCodeIn),
    .decValidOut(decValidOut), .decDataOut(decDataOut),
    .decSyndrome(decSyndrome), .decError(decError)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doEncode(input logic [3:0] d);
    @(negedge clk);
    encValidIn = 1'b1; encDataIn = d;
    @(negedge clk);
    encValidIn = 1'b0;
  endtask

  task automatic doDecode(input logic [6:0] w);
    @(negedge clk);
    decValidIn = 1'b1; decCodeIn = w;
    @(negedge clk);
    decValidIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "encValidOut", int'(encValidOut), 0);
    check("R9", "encCodeOut", int'(encCodeOut), 0);
    check("R9", "decValidOut", int'(decValidOut), 0);
    check("R9", "decDataOut", int'(decDataOut), 0);
    check("R9", "decSyndrome", int'(decSyndrome), 0);
    check("R9", "decError", int'(decError), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] d;
      logic [6:0] w;
      d = VEC[i][10:7];
      w = VEC[i][6:0];
      doEncode(d);
      check("R2", "encValidOut", int'(encValidOut), 1);
      check("R1", "encCodeOut", int'(encCodeOut), int'(w));
      for (int p = 0; p <= 7; p++) begin
        logic [6:0] rx;
        rx = w;
        if (p != 0) rx[p-1] = ~rx[p-1];
        doDecode(rx);
        check("R7", "decValidOut", int'(decValidOut), 1);
        // R3 R4 R5: syndrome equals flipped position, data repaired
        check(p == 0 ? "R4" : "R5", "decDataOut", int'(decDataOut), int'(d));
        check("R3", "decSyndrome", int'(decSyndrome), p);
        check("R6", "decError", int'(decError), int'(p != 0));
      end
    end

    // R2 R7: valid out drops one cycle later
    @(negedge clk);
    check("R2", "encValidOut idle", int'(encValidOut), 0);
    check("R7", "decValidOut idle", int'(decValidOut), 0);

    // R10: worked example
    doEncode(4'b1011);
    check("R10", "encode 1011", int'(encCodeOut), 7'b1010101);
    doDecode(7'b1000101);
    check("R10", "syndrome", int'(decSyndrome), 3'b101);
    check("R10", "data", int'(decDataOut), 4'b1011);

    // R8: inputs change while valid low
    @(negedge clk);
    encDataIn = 4'b0110; decCodeIn = 7'b0000001;
    repeat (3) @(negedge clk);
    check("R8", "encCodeOut held", int'(encCodeOut), 7'b1010101);
    check("R8", "decSyndrome held", int'(decSyndrome), 3'b101);
    check("R8", "decDataOut held", int'(decDataOut), 4'b1011);
    check("R8", "decError held", int'(decError), 1);

    // R11: double error gives miscorrection at XOR of positions
    doDecode(7'b1010101 ^ 7'b0000011);
    check("R11", "syndrome", int'(decSyndrome), 3);
    check("R11", "error", int'(decError), 1);
    check("R11", "data", int'(decDataOut), 4'b1010);

    // R9: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "encCodeOut after reset", int'(encCodeOut), 0);
    check("R9", "decSyndrome after reset", int'(decSyndrome), 0);
    check("R9", "decError after reset", int'(decError), 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule